// File: doc/BRIEF.md
# Shared Hardware Lock Bank

This block holds a small bank of lock bits that several processor cores share, both for mutual exclusion and for passing simple events between cores. Every core has its own request port. It presents an opcode and a lock index with a valid strobe, and it holds them until it sees its acknowledge pulse. A single rotating arbiter picks one request per cycle. Each read-modify-write of a lock bit is therefore indivisible, and the prior value comes back as a result flag. A zero from a set means the requester now owns the lock.

Alongside the lock bits there is a separate allocation register. Cores use it to hand out and give back lock numbers. The lock operations never touch this register, and allocation never touches the lock bits. A core can also watch one lock. Whenever any core makes that lock rise or fall, the watching core gets a one-cycle event pulse, which lets a lock act as a signalling flag.

Top module: `hwlock_bank`

## Requirements
- R1: The bank holds NLOCKS lock bits (default 16, at most 32), addressed by index 0 to NLOCKS-1. Index NLOCKS-1 works like any other index.
- R2: Opcode 2 (set) returns the lock's prior state on `flag` and leaves the lock at 1.
- R3: Opcode 3 (clear) returns the lock's prior state on `flag` and leaves the lock at 0.
- R4: Opcode 6 (waiting set) gives no acknowledge while the lock is 1. It retries on every cycle it is granted. Once it observes the lock at 0 it sets the lock and acknowledges with `flag` = 0.
- R5: Opcode 4 (get) returns the lock's state on `flag` without changing it.
- R6: Opcode 5 (toggle) inverts the lock and returns its old value on `flag`.
- R7: Opcode 0 (allocate) claims the lowest clear bit of the allocation register and returns its index on `alloc_idx` with `flag` = 0. If no bit is clear, it returns `flag` = 1. Opcode 1 (return) clears the allocation bit of the given index and returns that bit's prior value on `flag`. Neither opcode changes any lock bit, and opcodes 2, 3, 5 and 6 never change an allocation bit.
- R8: When several cores request at once, exactly one is granted per cycle, under rotating priority. A denied core's request stays pending until it is granted, and every request is acknowledged exactly once.
- R9: Opcode 7 arms the requesting core's watch on the given index, and opcode 8 disarms it. While the watch is armed, any 0-to-1 or 1-to-0 change of that lock, caused by any core, gives the watcher a one-cycle `lock_event` pulse, in the same cycle as the changing core's acknowledge.
- R10: If an indexed opcode (1 to 7) names an index of NLOCKS or above, or the opcode is above 8, the request is acknowledged with `err` = 1 and `flag` = 0, and no state changes.
- R11: Reset clears every lock bit, every allocation bit and every watch.
- R12: `ack`, `flag` and `err` are registered one-cycle pulses. An uncontested request is acknowledged on the clock edge that follows the edge where it is first presented. A core's next request is considered from the cycle after its acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | NCORES | Per-core request strobe, held until `ack` |
| req_op | input | NCORES*4 | Per-core opcode, core c in bits [4c+3:4c] |
| req_idx | input | NCORES*5 | Per-core lock index, core c in bits [5c+4:5c] |
| ack | output | NCORES | Per-core completion pulse |
| flag | output | NCORES | Result flag, valid with `ack` |
| err | output | NCORES | Bad index or opcode, valid with `ack` |
| alloc_idx | output | NCORES*5 | Index claimed by the core's last allocate |
| lock_event | output | NCORES | Per-core one-cycle watch event |

## Verification
Two situations are hard to reach from the ports. One is a waiting set that keeps being granted but must stay unacknowledged. The other is contention, where every core races for the same lock in one cycle. The bench parks one core on a waiting set for a lock that another core holds, confirms that no acknowledge appears, then releases the lock from the holder and expects the waiting core to complete with the lock taken. For contention, all cores issue a set on the same lock in the same cycle. The bench expects exactly one zero flag and four single acknowledges that never coincide.

// File: rtl/hwlock_bank.sv
module hwlock_bank #(
  parameter int NCORES = 4,
  parameter int NLOCKS = 16,
  parameter int IW     = 5,
  parameter int OPW    = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NCORES-1:0]     req_valid,
  input  logic [NCORES*OPW-1:0] req_op,
  input  logic [NCORES*IW-1:0]  req_idx,
  output logic [NCORES-1:0]     ack,
  output logic [NCORES-1:0]     flag,
  output logic [NCORES-1:0]     err,
  output logic [NCORES*IW-1:0]  alloc_idx,
  output logic [NCORES-1:0]     lock_event
);
  localparam int CW = (NCORES > 1) ? $clog2(NCORES) : 1;
  localparam int LW = (NLOCKS > 1) ? $clog2(NLOCKS) : 1;

  localparam logic [OPW-1:0] OP_ALLOC = 4'd0, OP_FREE  = 4'd1, OP_SET   = 4'd2,
                             OP_CLR   = 4'd3, OP_GET   = 4'd4, OP_TOG   = 4'd5,
                             OP_SETW  = 4'd6, OP_WATCH = 4'd7, OP_UNW   = 4'd8;

  logic [NLOCKS-1:0] lock_q, lock_d, own_q, own_d;
  logic [NCORES-1:0] done_q, flag_q, err_q, evt_q, wen_q, pend;
  logic [LW-1:0]     wsel_q [NCORES];
  logic [IW-1:0]     aidx_q [NCORES];
  logic [CW-1:0]     ptr_q, gsel;
  logic              gvalid;

  assign pend = req_valid & ~done_q;

  always_comb begin
    gvalid = 1'b0;
    gsel   = ptr_q;
    for (int k = NCORES - 1; k >= 0; k--) begin
      int c;
      c = (int'(ptr_q) + k) % NCORES;
      if (pend[c]) begin
        gvalid = 1'b1;
        gsel   = CW'(c);
      end
    end
  end

  logic [OPW-1:0] gop;
  logic [IW-1:0]  gidx;
  logic [LW-1:0]  li, free_idx;
  logic           needs_idx, bad, cur, rflag, stall;

  assign gop       = req_op[int'(gsel)*OPW +: OPW];
  assign gidx      = req_idx[int'(gsel)*IW +: IW];
  assign li        = gidx[LW-1:0];
  assign needs_idx = (gop >= OP_FREE) && (gop <= OP_WATCH);
  assign bad       = (gop > OP_UNW) || (needs_idx && int'(gidx) >= NLOCKS);
  assign cur       = lock_q[li];

  always_comb begin
    free_idx = '0;
    for (int i = NLOCKS - 1; i >= 0; i--)
      if (!own_q[i]) free_idx = LW'(i);
  end

  always_comb begin
    lock_d = lock_q;
    own_d  = own_q;
    rflag  = 1'b0;
    stall  = 1'b0;
    if (gvalid && !bad) begin
      case (gop)
        OP_ALLOC: begin
          rflag = &own_q;
          if (!rflag) own_d[free_idx] = 1'b1;
        end
        OP_FREE: begin rflag = own_q[li]; own_d[li] = 1'b0; end
        OP_SET:  begin rflag = cur; lock_d[li] = 1'b1; end
        OP_CLR:  begin rflag = cur; lock_d[li] = 1'b0; end
        OP_GET:  rflag = cur;
        OP_TOG:  begin rflag = cur; lock_d[li] = ~cur; end
        OP_SETW: begin
          if (cur) stall = 1'b1;
          else     lock_d[li] = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q <= '0;
      own_q  <= '0;
      done_q <= '0;
      flag_q <= '0;
      err_q  <= '0;
      evt_q  <= '0;
      wen_q  <= '0;
      ptr_q  <= '0;
      for (int c = 0; c < NCORES; c++) begin
        wsel_q[c] <= '0;
        aidx_q[c] <= '0;
      end
    end else begin
      lock_q <= lock_d;
      own_q  <= own_d;
      done_q <= '0;
      flag_q <= '0;
      err_q  <= '0;
      if (gvalid) begin
        ptr_q <= (int'(gsel) == NCORES - 1) ? '0 : gsel + 1'b1;
        if (!stall) begin
          done_q[gsel] <= 1'b1;
          flag_q[gsel] <= rflag;
          err_q[gsel]  <= bad;
          if (!bad && gop == OP_ALLOC && !rflag) aidx_q[gsel] <= IW'(free_idx);
          if (!bad && gop == OP_WATCH) begin
            wen_q[gsel]  <= 1'b1;
            wsel_q[gsel] <= li;
          end
          if (!bad && gop == OP_UNW) wen_q[gsel] <= 1'b0;
        end
      end
      for (int c = 0; c < NCORES; c++)
        evt_q[c] <= wen_q[c] && (lock_d[wsel_q[c]] != lock_q[wsel_q[c]]);
    end
  end

  assign ack        = done_q;
  assign flag       = flag_q;
  assign err        = err_q;
  assign lock_event = evt_q;

  for (genvar g = 0; g < NCORES; g++) begin : g_aidx
    assign alloc_idx[g*IW +: IW] = aidx_q[g];
  end
endmodule

// File: rtl/hwlock_bank_chk.sv
module hwlock_bank_chk #(
  parameter int NCORES = 4,
  parameter int NLOCKS = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NCORES-1:0] req_valid,
  input logic [NCORES-1:0] ack,
  input logic [NCORES-1:0] err,
  input logic [NCORES-1:0] flag,
  input logic [NCORES-1:0] lock_event,
  input logic [NCORES-1:0] wen,
  input logic [NLOCKS-1:0] lock_st,
  input logic [NLOCKS-1:0] own_st
);
  assert_one_grant_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ack));

  assert_ack_needs_req_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (ack != '0) |-> ((ack & ~$past(req_valid)) == '0));

  assert_err_with_ack_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ((err | flag) & ~ack) == '0);

  assert_single_bit_change_R8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ($countones(lock_st ^ $past(lock_st)) <= 1));

  assert_lock_change_acked_R12: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((lock_st == $past(lock_st)) || (ack != '0)));

  assert_regs_separate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> !((lock_st != $past(lock_st)) && (own_st != $past(own_st))));

  assert_event_needs_watch_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_event & ~wen) == '0);
endmodule

bind hwlock_bank hwlock_bank_chk #(.NCORES(NCORES), .NLOCKS(NLOCKS)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .ack        (ack),
  .err        (err),
  .flag       (flag),
  .lock_event (lock_event),
  .wen        (wen_q),
  .lock_st    (lock_q),
  .own_st     (own_q)
);

// File: tb/hwlock_bank_tb_top.sv
module hwlock_bank_tb_top;
  localparam int NC = 4;
  localparam int NL = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NC-1:0] req_valid = '0;
  logic [NC*4-1:0] req_op = '0;
  logic [NC*5-1:0] req_idx = '0;
  logic [NC-1:0] ack, flag, err, lock_event;
  logic [NC*5-1:0] alloc_idx;

  always #5 clk = ~clk;

  hwlock_bank #(.NCORES(NC), .NLOCKS(NL)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_idx(req_idx), .ack(ack), .flag(flag), .err(err),
    .alloc_idx(alloc_idx), .lock_event(lock_event)
  );

  int checks = 0;
  int errors = 0;
  logic [NC-1:0] last_evt;
  int last_n;

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", r, act, exp);
    end
  endtask

  task automatic do_op(input int c, input logic [3:0] op, input logic [4:0] idx,
                       output logic f, output logic e, output logic [4:0] ai);
    int n;
    n = 0;
    @(negedge clk);
    req_valid[c] = 1'b1;
    req_op[c*4 +: 4] = op;
    req_idx[c*5 +: 5] = idx;
    do begin
      @(negedge clk);
      n++;
    end while (!ack[c] && n < 50);
    f = flag[c];
    e = err[c];
    ai = alloc_idx[c*5 +: 5];
    last_evt = lock_event;
    last_n = n;
    req_valid[c] = 1'b0;
    if (n >= 50) begin
      errors++;
      $display("FAIL R12 actual no-ack expected ack");
    end
  endtask

  function automatic string tag(input logic [3:0] op, input logic ee);
    if (ee) return "R10";
    case (op)
      4'd0, 4'd1: return "R7";
      4'd2: return "R2";
      4'd3: return "R3";
      4'd4: return "R5";
      4'd5: return "R6";
      4'd6: return "R4";
      default: return "R10";
    endcase
  endfunction

  // {op[3:0], idx[4:0], expected flag, expected err}
  localparam int NV = 21;
  localparam logic [10:0] VEC [NV] = '{
    {4'd4, 5'd3,  1'b0, 1'b0},
    {4'd2, 5'd3,  1'b0, 1'b0},
    {4'd2, 5'd3,  1'b1, 1'b0},
    {4'd4, 5'd3,  1'b1, 1'b0},
    {4'd3, 5'd3,  1'b1, 1'b0},
    {4'd3, 5'd3,  1'b0, 1'b0},
    {4'd5, 5'd7,  1'b0, 1'b0},
    {4'd5, 5'd7,  1'b1, 1'b0},
    {4'd4, 5'd7,  1'b0, 1'b0},
    {4'd2, 5'd15, 1'b0, 1'b0},
    {4'd3, 5'd15, 1'b1, 1'b0},
    {4'd2, 5'd16, 1'b0, 1'b1},
    {4'd4, 5'd31, 1'b0, 1'b1},
    {4'd9, 5'd0,  1'b0, 1'b1},
    {4'd0, 5'd0,  1'b0, 1'b0},
    {4'd4, 5'd0,  1'b0, 1'b0},
    {4'd1, 5'd0,  1'b1, 1'b0},
    {4'd1, 5'd0,  1'b0, 1'b0},
    {4'd6, 5'd5,  1'b0, 1'b0},
    {4'd3, 5'd5,  1'b1, 1'b0},
    {4'd4, 5'd0,  1'b0, 1'b0}
  };

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic f, e;
    logic [4:0] ai;
    repeat (3) @(negedge clk);
    chk("R11 ack after reset", 32'(ack), 32'h0);
    chk("R11 event after reset", 32'(lock_event), 32'h0);
    rst_n = 1'b1;

    for (int v = 0; v < NV; v++) begin
      do_op(0, VEC[v][10:7], VEC[v][6:2], f, e, ai);
      chk({tag(VEC[v][10:7], VEC[v][0]), " vec flag"}, 32'(f), 32'(VEC[v][1]));
      chk({tag(VEC[v][10:7], VEC[v][0]), " vec err"}, 32'(e), 32'(VEC[v][0]));
      chk("R12 ack latency", 32'(last_n), 32'd1);
    end

    // R7 lowest free allocation, separate from lock bits
    do_op(1, 4'd0, 5'd0, f, e, ai); chk("R7 alloc first", 32'(ai), 32'd0);
    do_op(1, 4'd0, 5'd0, f, e, ai); chk("R7 alloc second", 32'(ai), 32'd1);
    do_op(1, 4'd0, 5'd0, f, e, ai); chk("R7 alloc third", 32'(ai), 32'd2);
    do_op(1, 4'd1, 5'd1, f, e, ai); chk("R7 return flag", 32'(f), 32'd1);
    do_op(2, 4'd0, 5'd0, f, e, ai); chk("R7 reuse lowest", 32'(ai), 32'd1);
    for (int k = 3; k < NL; k++) do_op(1, 4'd0, 5'd0, f, e, ai);
    do_op(1, 4'd0, 5'd0, f, e, ai); chk("R7 none free flag", 32'(f), 32'd1);
    do_op(1, 4'd4, 5'd2, f, e, ai); chk("R7 lock untouched", 32'(f), 32'd0);
    do_op(1, 4'd2, 5'd9, f, e, ai);
    do_op(1, 4'd1, 5'd9, f, e, ai); chk("R7 alloc kept by set", 32'(f), 32'd1);
    do_op(1, 4'd3, 5'd9, f, e, ai);
    for (int k = 0; k < NL; k++) do_op(1, 4'd1, 5'(k), f, e, ai);
    do_op(3, 4'd0, 5'd0, f, e, ai); chk("R7 freed all", 32'(ai), 32'd0);

    // R4 waiting set blocks while held
    do_op(0, 4'd2, 5'd9, f, e, ai);
    @(negedge clk);
    req_valid[1] = 1'b1; req_op[7:4] = 4'd6; req_idx[9:5] = 5'd9;
    begin
      int seen;
      seen = 0;
      repeat (6) begin @(negedge clk); if (ack[1]) seen++; end
      chk("R4 no ack while held", 32'(seen), 32'd0);
      do_op(0, 4'd3, 5'd9, f, e, ai);
      chk("R4 holder release flag", 32'(f), 32'd1);
      seen = 0;
      for (int k = 0; k < 10 && seen == 0; k++) begin
        @(negedge clk);
        if (ack[1]) begin seen = 1; chk("R4 waiter flag", 32'(flag[1]), 32'd0); end
      end
      chk("R4 waiter acked", 32'(seen), 32'd1);
      req_valid[1] = 1'b0;
    end
    do_op(2, 4'd4, 5'd9, f, e, ai); chk("R4 lock taken", 32'(f), 32'd1);
    do_op(2, 4'd3, 5'd9, f, e, ai);

    // R8 contention: all cores set lock 4 at once
    @(negedge clk);
    for (int c = 0; c < NC; c++) begin
      req_valid[c] = 1'b1; req_op[c*4 +: 4] = 4'd2; req_idx[c*5 +: 5] = 5'd4;
    end
    begin
      logic [NC-1:0] got;
      int wins, multi, dup;
      got = '0; wins = 0; multi = 0; dup = 0;
      for (int k = 0; k < 20; k++) begin
        @(negedge clk);
        if ($countones(ack) > 1) multi++;
        for (int c = 0; c < NC; c++) if (ack[c]) begin
          if (got[c]) dup++;
          got[c] = 1'b1;
          if (!flag[c]) wins++;
          req_valid[c] = 1'b0;
        end
      end
      chk("R8 all acked", 32'(got), 32'hf);
      chk("R8 single winner", 32'(wins), 32'd1);
      chk("R8 one ack per cycle", 32'(multi), 32'd0);
      chk("R8 no duplicate ack", 32'(dup), 32'd0);
    end
    do_op(0, 4'd3, 5'd4, f, e, ai);

    // R9 watch events
    do_op(2, 4'd7, 5'd6, f, e, ai);
    do_op(0, 4'd2, 5'd6, f, e, ai);
    chk("R9 rise event", 32'(last_evt), 32'h4);
    @(negedge clk);
    chk("R9 event one cycle", 32'(lock_event), 32'h0);
    do_op(1, 4'd5, 5'd6, f, e, ai);
    chk("R9 fall event", 32'(last_evt), 32'h4);
    do_op(3, 4'd4, 5'd6, f, e, ai);
    chk("R9 no event on get", 32'(last_evt), 32'h0);
    do_op(2, 4'd8, 5'd0, f, e, ai);
    do_op(0, 4'd2, 5'd6, f, e, ai);
    chk("R9 disarmed", 32'(last_evt), 32'h0);
    do_op(2, 4'd7, 5'd6, f, e, ai);

    // R11 reset mid-run
    do_op(0, 4'd0, 5'd0, f, e, ai);
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk); rst_n = 1'b1;
    do_op(1, 4'd0, 5'd0, f, e, ai); chk("R11 alloc cleared", 32'(ai), 32'd0);
    do_op(1, 4'd4, 5'd6, f, e, ai); chk("R11 lock cleared", 32'(f), 32'd0);
    do_op(0, 4'd2, 5'd6, f, e, ai); chk("R11 watch cleared", 32'(last_evt), 32'h0);

    // R1 top index and R10 no change on bad index
    do_op(3, 4'd5, 5'd15, f, e, ai); chk("R1 top index toggle", 32'(f), 32'd0);
    do_op(3, 4'd3, 5'd16, f, e, ai); chk("R10 bad clear err", 32'(e), 32'd1);
    do_op(3, 4'd4, 5'd15, f, e, ai); chk("R10 state intact", 32'(f), 32'd1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule